// File: doc/BRIEF.md
# Three-Pair Motor PWM Modulator

This block generates the gate drive pattern for a three-phase inverter bridge. A 12-bit up counter is clocked through a power-of-two prescaler. The counter restarts from zero once it reaches a programmable period value. Six signed duty values are compared with the count. The six resulting outputs can be used on their own, or grouped into three high/low pairs. In the paired mode each low side is the inverse of its high side, and a programmable dead time separates every change of state.

A host programs the block through a single-cycle register write port. Period, duty and prescale writes go into shadow copies, which are taken over at the wrap of the counter. Those copies are also taken over continuously while the counter is stopped. Dead time and the output controls take effect at once. Fault inputs are latched into write-1-to-clear flags and force every pin to a safe level chosen per side. The block then restarts either automatically, at a period boundary, or as soon as software has cleared the flags.

Top module: `cpwm_bridge`

Register map (word address on `wr_addr`):
- Address 0 is the control word:
  - bit 0: run
  - bit 1: output enable
  - bit 2: paired mode
  - bits 4:3: prescale exponent
  - bit 5: automatic restart
  - bit 6: invert high side
  - bit 7: invert low side
  - bit 8: high-side off level
  - bit 9: low-side off level
- Address 1 holds the period.
- Address 2 holds the dead time.
- Address 3 is the clear register. Bit n clears fault flag n, and bit 15 clears the wrap flag.
- Addresses 4 to 9 hold the duties of outputs 0 to 5. Even outputs are high sides and odd outputs are low sides.

## Requirements
- R1: While run is 1, `count` advances by one per prescaled tick from 0 up to the active period and then returns to 0; while run is 0 it is held at 0.
- R2: A prescale exponent p gives one tick every 2^p clocks (p = 0 to 3); a new exponent written while running is adopted only at the next wrap.
- R3: An output's demand is active while count < duty; a duty with bit 15 set is inactive for the whole period, and a duty at or above the period is active for the whole period.
- R4: Writes to period, duty and prescale land in shadow copies that become active at the wrap (or continuously while run is 0).
- R5: With paired mode 0, each of the six outputs follows its own duty register.
- R6: With paired mode 1, the high output of pair k follows duty 2k. The low output is its inverse and ignores duty 2k+1. Each change of the high demand holds both outputs of the pair inactive for max(D,1) clocks, where D is the dead-time value.
- R7: In paired mode the two outputs of a pair are never active in the same cycle.
- R8: A driven pin equals the active demand XOR the invert bit of its side; an undriven pin shows its side's off level; after reset every pin is 0.
- R9: With output enable 0, all pins show their off levels from the cycle after the control write lands, independent of the counter.
- R10: A high fault input sets its flag and forces all pins to the off level from the next clock. A 1 written to the flag's clear bit clears it, except that a fault still high in that cycle wins.
- R11: With automatic restart, driving resumes only at a wrap at which all fault inputs are low and all flags are clear.
- R12: With automatic restart 0, driving resumes one clock after the flags are cleared, with fault inputs low, without waiting for a wrap.
- R13: The wrap flag sets at every counter wrap and is cleared by writing 1 to bit 15 of the clear register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register word address |
| wr_data | input | 16 | Register write data |
| fault_in | input | 2 | Fault sources, active high |
| pwm_out | output | 6 | Gate outputs; even indices high side, odd indices low side |
| count | output | 12 | Current counter value |
| fault_flags | output | 2 | Latched fault flags |
| reload_flag | output | 1 | Period wrap flag |

## Verification
Two pairs of events can land on the same clock edge. The first is a fault input still being high while its clear bit is written. The bench holds a fault input high across a clear write and expects the flag to stay set; it then repeats the clear with the input low and expects the flag to drop. The second is a flag clear against the counter wrap. The clear is written at an arbitrary point in the period, and the pins are sampled at the last count of the period and again at count 0. They must still be off at the last count and driven again at count 0. This shows that the release waits for the first wrap after the clear and not for a wrap that coincides with it.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

   localparam int PRE_W      = 2;
   localparam int ADR_CTRL   = 0;
   localparam int ADR_PERIOD = 1;
   localparam int ADR_DEAD   = 2;
   localparam int ADR_CLEAR  = 3;
   localparam int ADR_DUTY   = 4;

   typedef struct packed {
      logic             lo_off;
      logic             hi_off;
      logic             lo_inv;
      logic             hi_inv;
      logic             auto_rec;
      logic [PRE_W-1:0] pres;
      logic             paired;
      logic             out_en;
      logic             run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
   import cpwm_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int DUTY_W = 16,
   parameter int NCH    = 6
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         run,
   input  logic [PRE_W-1:0]             pres_sh,
   input  logic [CNT_W-1:0]             per_sh,
   input  logic [NCH-1:0][DUTY_W-1:0]   duty_sh,
   output logic [CNT_W-1:0]             cnt,
   output logic [CNT_W-1:0]             per_act,
   output logic [PRE_W-1:0]             pres_act,
   output logic [NCH-1:0][DUTY_W-1:0]   duty_act,
   output logic                         wrap
);

   localparam int PC_W = (2 ** PRE_W) - 1;

   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] pc_lim;
   logic            tick;

   assign pc_lim = PC_W'((PC_W+1)'(1) << pres_act) - PC_W'(1);
   assign tick   = (pc == pc_lim);
   assign wrap   = run && tick && (cnt == per_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         pc       <= '0;
         per_act  <= '0;
         pres_act <= '0;
         duty_act <= '0;
      end else if (!run) begin
         cnt      <= '0;
         pc       <= '0;
         per_act  <= per_sh;
         pres_act <= pres_sh;
         duty_act <= duty_sh;
      end else begin
         pc <= tick ? '0 : pc + PC_W'(1);
         if (tick) begin
            if (cnt == per_act) begin
               cnt      <= '0;
               per_act  <= per_sh;
               pres_act <= pres_sh;
               duty_act <= duty_sh;
            end else begin
               cnt <= cnt + CNT_W'(1);
            end
         end
      end
   end

endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair #(
   parameter int CNT_W  = 12,
   parameter int DUTY_W = 16,
   parameter int DB_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              paired,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [CNT_W-1:0]  per,
   input  logic [DUTY_W-1:0] duty_h,
   input  logic [DUTY_W-1:0] duty_l,
   input  logic [DB_W-1:0]   dead,
   output logic              raw_h,
   output logic              raw_l
);

   localparam int MW = DUTY_W - 1;

   function automatic logic demand(input logic [DUTY_W-1:0] d,
                                   input logic [CNT_W-1:0]  c,
                                   input logic [CNT_W-1:0]  p);
      return !d[DUTY_W-1] && ((d[MW-1:0] >= MW'(p)) || (MW'(c) < d[MW-1:0]));
   endfunction

   logic            req_h;
   logic            req_l;
   logic            prev_h;
   logic [DB_W-1:0] hold;
   logic            settled;

   assign req_h   = demand(duty_h, cnt, per);
   assign req_l   = demand(duty_l, cnt, per);
   assign settled = (prev_h == req_h) && (hold == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_h <= 1'b0;
         hold   <= '0;
      end else begin
         prev_h <= req_h;
         if (prev_h != req_h)
            hold <= (dead == '0) ? '0 : dead - DB_W'(1);
         else if (hold != '0)
            hold <= hold - DB_W'(1);
      end
   end

   assign raw_h = paired ? (req_h && settled)  : req_h;
   assign raw_l = paired ? (!req_h && settled) : req_l;

endmodule

// File: rtl/cpwm_guard.sv
module cpwm_guard #(
   parameter int NFLT = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NFLT-1:0] fault_in,
   input  logic            clr_wr,
   input  logic [NFLT-1:0] clr_bits,
   input  logic            auto_rec,
   input  logic            wrap,
   output logic [NFLT-1:0] flags,
   output logic            blocked
);

   logic [NFLT-1:0] clr_mask;
   logic            may_go;

   assign clr_mask = clr_wr ? clr_bits : '0;
   assign may_go   = (flags == '0) && (auto_rec ? wrap : 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags   <= '0;
         blocked <= 1'b0;
      end else begin
         flags <= (flags & ~clr_mask) | fault_in;
         if (|fault_in)
            blocked <= 1'b1;
         else if (blocked && may_go)
            blocked <= 1'b0;
      end
   end

endmodule

// File: rtl/cpwm_bridge.sv
module cpwm_bridge
   import cpwm_pkg::*;
#(
   parameter int CNT_W  = 12,
   parameter int DUTY_W = 16,
   parameter int DB_W   = 8,
   parameter int NPAIR  = 3,
   parameter int NFLT   = 2,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [NFLT-1:0]   fault_in,
   output logic [2*NPAIR-1:0] pwm_out,
   output logic [CNT_W-1:0]  count,
   output logic [NFLT-1:0]   fault_flags,
   output logic              reload_flag
);

   localparam int NCH = 2 * NPAIR;

   if (DUTY_W < CNT_W + 1) begin : g_bad_duty
      $error("duty width must exceed counter width by a sign bit");
   end
   if (DATA_W < DUTY_W || DATA_W < CNT_W || DATA_W < CTRL_W || DATA_W < DB_W) begin : g_bad_data
      $error("write data too narrow");
   end
   if (NFLT >= DATA_W) begin : g_bad_flt
      $error("fault count collides with wrap-clear bit");
   end
   if (ADR_DUTY + NCH > (2 ** ADDR_W)) begin : g_bad_addr
      $error("address space too small for duty registers");
   end

   ctrl_t                      ctrl;
   logic [CNT_W-1:0]           per_sh;
   logic [DB_W-1:0]            dead;
   logic [NCH-1:0][DUTY_W-1:0] duty_sh;
   logic [NCH-1:0][DUTY_W-1:0] duty_act;
   logic [CNT_W-1:0]           cnt;
   logic [CNT_W-1:0]           per_act;
   logic [PRE_W-1:0]           pres_act;
   logic                       wrap;
   logic [NCH-1:0]             raw;
   logic                       clr_wr;
   logic                       blocked;
   logic                       drive;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl    <= '0;
         per_sh  <= '0;
         dead    <= '0;
         duty_sh <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_W'(ADR_CTRL))
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
         if (wr_addr == ADDR_W'(ADR_PERIOD))
            per_sh <= wr_data[CNT_W-1:0];
         if (wr_addr == ADDR_W'(ADR_DEAD))
            dead <= wr_data[DB_W-1:0];
         for (int i = 0; i < NCH; i++)
            if (wr_addr == ADDR_W'(ADR_DUTY + i))
               duty_sh[i] <= wr_data[DUTY_W-1:0];
      end
   end

   assign clr_wr = wr_en && (wr_addr == ADDR_W'(ADR_CLEAR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reload_flag <= 1'b0;
      else if (wrap)
         reload_flag <= 1'b1;
      else if (clr_wr && wr_data[DATA_W-1])
         reload_flag <= 1'b0;
   end

   cpwm_timebase #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .NCH(NCH)) u_timebase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ctrl.run),
      .pres_sh  (ctrl.pres),
      .per_sh   (per_sh),
      .duty_sh  (duty_sh),
      .cnt      (cnt),
      .per_act  (per_act),
      .pres_act (pres_act),
      .duty_act (duty_act),
      .wrap     (wrap)
   );

   for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      cpwm_pair #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .DB_W(DB_W)) u_pair (
         .clk    (clk),
         .rst_n  (rst_n),
         .paired (ctrl.paired),
         .cnt    (cnt),
         .per    (per_act),
         .duty_h (duty_act[2*k]),
         .duty_l (duty_act[2*k+1]),
         .dead   (dead),
         .raw_h  (raw[2*k]),
         .raw_l  (raw[2*k+1])
      );
   end

   cpwm_guard #(.NFLT(NFLT)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .fault_in (fault_in),
      .clr_wr   (clr_wr),
      .clr_bits (wr_data[NFLT-1:0]),
      .auto_rec (ctrl.auto_rec),
      .wrap     (wrap),
      .flags    (fault_flags),
      .blocked  (blocked)
   );

   assign drive = ctrl.out_en && !blocked;
   assign count = cnt;

   for (genvar i = 0; i < NCH; i++) begin : g_pin
      if (i % 2 == 0) begin : g_high
         assign pwm_out[i] = drive ? (raw[i] ^ ctrl.hi_inv) : ctrl.hi_off;
      end else begin : g_low
         assign pwm_out[i] = drive ? (raw[i] ^ ctrl.lo_inv) : ctrl.lo_off;
      end
   end

endmodule

// File: rtl/cpwm_bridge_chk.sv
module cpwm_bridge_chk #(
   parameter int NPAIR = 3,
   parameter int CNT_W = 12,
   parameter int NFLT  = 2,
   parameter int PRE_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               paired,
   input logic               auto_rec,
   input logic               hi_off,
   input logic               lo_off,
   input logic [2*NPAIR-1:0] raw,
   input logic [2*NPAIR-1:0] pwm_out,
   input logic [CNT_W-1:0]   cnt,
   input logic [CNT_W-1:0]   per_act,
   input logic [PRE_W-1:0]   pres_act,
   input logic               wrap,
   input logic               reload_flag,
   input logic [NFLT-1:0]    fault_in,
   input logic               blocked
);

   logic [2*NPAIR-1:0] off_vec;

   for (genvar i = 0; i < 2 * NPAIR; i++) begin : g_off
      assign off_vec[i] = (i % 2 == 0) ? hi_off : lo_off;
   end

   assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= per_act);

   assert_prescale_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !wrap) |=> $stable(pres_act));

   for (genvar k = 0; k < NPAIR; k++) begin : g_excl
      assert_pair_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
         paired |-> !(raw[2*k] && raw[2*k+1]));
   end

   assert_fault_forces_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (|fault_in) |=> (pwm_out == off_vec));

   assert_auto_resume_at_wrap_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(blocked) && $past(auto_rec)) |-> $past(wrap));

   assert_wrap_sets_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> reload_flag);

endmodule

bind cpwm_bridge cpwm_bridge_chk #(.NPAIR(NPAIR), .CNT_W(CNT_W), .NFLT(NFLT), .PRE_W(cpwm_pkg::PRE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .run         (ctrl.run),
   .paired      (ctrl.paired),
   .auto_rec    (ctrl.auto_rec),
   .hi_off      (ctrl.hi_off),
   .lo_off      (ctrl.lo_off),
   .raw         (raw),
   .pwm_out     (pwm_out),
   .cnt         (cnt),
   .per_act     (per_act),
   .pres_act    (pres_act),
   .wrap        (wrap),
   .reload_flag (reload_flag),
   .fault_in    (fault_in),
   .blocked     (blocked)
);

// File: tb/test_cpwm_bridge.sv
module test_cpwm_bridge;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [1:0]  fault_in = '0;
   logic [5:0]  pwm_out;
   logic [11:0] count;
   logic [1:0]  fault_flags;
   logic        reload_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   cpwm_bridge i_cpwm_bridge (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fault_in(fault_in), .pwm_out(pwm_out), .count(count),
      .fault_flags(fault_flags), .reload_flag(reload_flag)
   );

   // bench-side view of the programmed state (updated once a write has landed)
   logic        m_run = 0, b_en = 0, b_hp = 0, b_lp = 0, b_hoff = 0, b_loff = 0;
   logic [1:0]  sh_pres = 0;
   logic [11:0] sh_rel = 0;
   logic [15:0] sh_duty [6];
   // reference timing model from the requirements
   logic [11:0] ec, m_rel_a;
   logic [1:0]  m_pres_a;
   int          pc;
   logic [15:0] m_act [6];

   initial for (int i = 0; i < 6; i++) sh_duty[i] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ec <= '0; pc <= 0; m_rel_a <= '0; m_pres_a <= '0;
         for (int i = 0; i < 6; i++) m_act[i] <= '0;
      end else if (!m_run) begin
         ec <= '0; pc <= 0; m_rel_a <= sh_rel; m_pres_a <= sh_pres;
         for (int i = 0; i < 6; i++) m_act[i] <= sh_duty[i];
      end else if (pc == (1 << m_pres_a) - 1) begin
         pc <= 0;
         if (ec == m_rel_a) begin
            ec <= '0; m_rel_a <= sh_rel; m_pres_a <= sh_pres;
            for (int i = 0; i < 6; i++) m_act[i] <= sh_duty[i];
         end else begin
            ec <= ec + 12'd1;
         end
      end else begin
         pc <= pc + 1;
      end
   end

   function automatic logic exp_act(input logic [15:0] d, input logic [11:0] c, input logic [11:0] r);
      return !d[15] && ((d[14:0] >= {3'b0, r}) || ({3'b0, c} < d[14:0]));
   endfunction

   function automatic logic [5:0] exp_vec();
      logic [5:0] v;
      for (int i = 0; i < 6; i++) begin
         if (b_en) v[i] = exp_act(m_act[i], ec, m_rel_a) ^ ((i % 2 == 1) ? b_lp : b_hp);
         else      v[i] = (i % 2 == 1) ? b_loff : b_hoff;
      end
      return v;
   endfunction

   function automatic logic [15:0] mk_ctrl(input logic run, input logic en, input logic pr,
                                           input logic [1:0] pres, input logic aut,
                                           input logic hp, input logic lp,
                                           input logic hoff, input logic loff);
      return {6'b0, loff, hoff, lp, hp, aut, pres, pr, en, run};
   endfunction

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      case (a)
         4'd0: begin
            m_run = d[0]; b_en = d[1]; sh_pres = d[4:3];
            b_hp = d[6]; b_lp = d[7]; b_hoff = d[8]; b_loff = d[9];
         end
         4'd1: sh_rel = d[11:0];
         4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: sh_duty[a - 4'd4] = d;
         default: ;
      endcase
   endtask

   task automatic run_check(input int n, input string rq);
      repeat (n) begin
         @(negedge clk);
         chk(count == ec, "R1 count", int'(count), int'(ec));
         chk(pwm_out == exp_vec(), rq, int'(pwm_out), int'(exp_vec()));
      end
   endtask

   task automatic wait_count(input logic [11:0] v);
      while (count != v) @(negedge clk);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(pwm_out == 6'h00, "R8 reset pins", int'(pwm_out), 0);
      chk(count == 12'd0, "R1 reset count", int'(count), 0);
      chk(fault_flags == 2'b00, "R10 reset flags", int'(fault_flags), 0);
      chk(reload_flag == 1'b0, "R13 reset flag", int'(reload_flag), 0);

      // R1 R2 R3 R5 R8: sweep prescale, period, duty set and polarity
      for (int cfg = 0; cfg < 8; cfg++) begin
         logic [11:0] r;
         logic [15:0] vals [6];
         r = (cfg < 4) ? 12'd5 : 12'd3;
         vals[0] = 16'hFFFD; vals[1] = 16'd0; vals[2] = 16'd1;
         vals[3] = {4'b0, r} - 16'd1; vals[4] = {4'b0, r}; vals[5] = {4'b0, r} + 16'd4;
         wr(4'd0, 16'd0);
         wr(4'd1, {4'b0, r});
         for (int i = 0; i < 6; i++) wr(4'(4 + i), vals[(i + cfg) % 6]);
         wr(4'd0, mk_ctrl(1, 1, 0, 2'(cfg % 4), 0, cfg[0], cfg[1], 0, 0));
         run_check(50, "R3 R5 R8 R2 pattern");
      end

      // R4 R2: shadow writes while running take effect at the wrap
      wr(4'd0, 16'd0);
      wr(4'd1, 16'd5);
      wr(4'd0, mk_ctrl(1, 1, 0, 2'd0, 0, 0, 0, 0, 0));
      run_check(3, "R4 before update");
      wr(4'd4, 16'd4);
      wr(4'd1, 16'd3);
      wr(4'd0, mk_ctrl(1, 1, 0, 2'd1, 0, 0, 0, 0, 0));
      run_check(30, "R4 R2 shadow update");

      // R9: output enable off is immediate
      wr(4'd0, mk_ctrl(1, 0, 0, 2'd1, 0, 0, 0, 1, 0));
      chk(pwm_out == 6'h15, "R9 disable off level", int'(pwm_out), 6'h15);
      run_check(10, "R9 held off");

      // R6 R7: paired mode with dead time D = 3, 1, 0
      for (int t = 0; t < 3; t++) begin
         int d, de, h0, l0, z0, b0, h1, l1, h2, l2;
         d  = (t == 0) ? 3 : ((t == 1) ? 1 : 0);
         de = (d == 0) ? 1 : d;
         wr(4'd0, 16'd0);
         wr(4'd1, 16'd15);
         wr(4'd2, 16'(d));
         wr(4'd4, 16'd8);  wr(4'd5, 16'd2);
         wr(4'd6, 16'd20); wr(4'd7, 16'd0);
         wr(4'd8, 16'hFFFB); wr(4'd9, 16'd15);
         wr(4'd0, mk_ctrl(1, 1, 1, 2'd0, 0, 0, 0, 0, 0));
         wait_count(12'd1);
         wait_count(12'd0);
         h0 = 0; l0 = 0; z0 = 0; b0 = 0; h1 = 0; l1 = 0; h2 = 0; l2 = 0;
         for (int s = 0; s < 16; s++) begin
            if (s > 0) @(negedge clk);
            h0 += int'(pwm_out[0]); l0 += int'(pwm_out[1]);
            z0 += int'(!pwm_out[0] && !pwm_out[1]);
            h1 += int'(pwm_out[2]); l1 += int'(pwm_out[3]);
            h2 += int'(pwm_out[4]); l2 += int'(pwm_out[5]);
            for (int k = 0; k < 3; k++) b0 += int'(pwm_out[2*k] && pwm_out[2*k+1]);
         end
         chk(h0 == 8 - de, "R6 high width", h0, 8 - de);
         chk(l0 == 8 - de, "R6 low width ignores odd duty", l0, 8 - de);
         chk(z0 == 2 * de, "R6 dead clocks", z0, 2 * de);
         chk(b0 == 0, "R7 overlap", b0, 0);
         chk(h1 == 16 && l1 == 0, "R6 R3 full duty pair", h1 * 100 + l1, 1600);
         chk(h2 == 0 && l2 == 16, "R6 R3 negative duty pair", h2 * 100 + l2, 16);
      end

      // R10 R11: fault with automatic restart
      wr(4'd0, 16'd0);
      wr(4'd1, 16'd7);
      for (int i = 0; i < 6; i++) wr(4'(4 + i), 16'h0100);
      wr(4'd0, mk_ctrl(1, 1, 0, 2'd0, 1, 0, 0, 0, 1));
      repeat (3) @(negedge clk);
      chk(pwm_out == 6'h3F, "R3 full on before fault", int'(pwm_out), 6'h3F);
      fault_in = 2'b01;
      @(negedge clk);
      fault_in = 2'b00;
      chk(pwm_out == 6'h2A, "R10 off after fault", int'(pwm_out), 6'h2A);
      chk(fault_flags == 2'b01, "R10 flag latched", int'(fault_flags), 1);
      repeat (20) @(negedge clk);
      chk(pwm_out == 6'h2A, "R11 stays off with flag set", int'(pwm_out), 6'h2A);
      wr(4'd3, 16'h0001);
      chk(fault_flags == 2'b00, "R10 flag cleared", int'(fault_flags), 0);
      wait_count(12'd7);
      chk(pwm_out == 6'h2A, "R11 off until wrap", int'(pwm_out), 6'h2A);
      @(negedge clk);
      chk(pwm_out == 6'h3F, "R11 driven after wrap", int'(pwm_out), 6'h3F);

      // R10: a fault held high wins over its clear
      fault_in = 2'b10;
      wr(4'd3, 16'h0002);
      chk(fault_flags[1] == 1'b1, "R10 set wins over clear", int'(fault_flags), 2);
      fault_in = 2'b00;
      wr(4'd3, 16'h0002);
      chk(fault_flags == 2'b00, "R10 clear after release", int'(fault_flags), 0);

      // R12: manual restart does not wait for the wrap
      wr(4'd0, mk_ctrl(1, 1, 0, 2'd3, 0, 0, 0, 0, 1));
      @(negedge clk);
      chk(pwm_out == 6'h3F, "R12 resumed on flag clear", int'(pwm_out), 6'h3F);
      fault_in = 2'b01;
      @(negedge clk);
      fault_in = 2'b00;
      chk(pwm_out == 6'h2A, "R10 R12 off after fault", int'(pwm_out), 6'h2A);
      wr(4'd3, 16'h0001);
      chk(pwm_out == 6'h2A, "R12 off as clear lands", int'(pwm_out), 6'h2A);
      @(negedge clk);
      chk(pwm_out == 6'h3F, "R12 driven one clock later", int'(pwm_out), 6'h3F);

      // R13: wrap flag set and cleared
      wait_count(12'd1);
      chk(reload_flag == 1'b1, "R13 flag set", int'(reload_flag), 1);
      wr(4'd3, 16'h8000);
      chk(reload_flag == 1'b0, "R13 flag cleared", int'(reload_flag), 0);
      wait_count(12'd0);
      @(negedge clk);
      chk(reload_flag == 1'b1, "R13 flag set again", int'(reload_flag), 1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule